// File: doc/BRIEF.md
# Addressing Mode Operand Fetch Unit

This unit fetches the source operand of a two-operand add for seven addressing modes. A caller presents an addressing mode code, three register numbers (destination, base, index), a 16-bit constant field and a 2-bit scale selector, and pulses `start`. The unit reads the base, index and destination registers through three combinational register-file read ports. It works out an effective address and issues one or two reads on a synchronous data-memory port. The operand then appears on `operand`. In the same cycle, a write-back of destination plus operand is presented on the `wb_*` port for the register file to store.

Register and immediate operands finish in one cycle. Single-read memory modes take two cycles. Memory indirect chains two reads: the value returned by the first read is fed straight back as the address of the second, and the operand arrives after three cycles. All fields are captured when `start` is accepted, so the caller may change them afterwards. Memory addresses keep only their low `AW` bits, so they wrap modulo the memory size.

Top module: `opnd_fetch_unit`

## Requirements
- R1: While and after reset, with no start, `done`, `wb_en` and `mem_rd_en` are 0.
- R2: Mode code 0 (immediate) gives the 16-bit field sign-extended to 32 bits. `done` is 1 in the cycle after the edge that samples `start`, and no memory read is issued.
- R3: Mode code 1 (register) gives the base register's content with one-cycle latency and no memory read. Register 0 is an ordinary register.
- R4: Mode code 2 (register indirect) gives memory at the base register's value. One read is made and `done` rises two cycles after the start edge.
- R5: Mode code 3 (direct) gives memory at the address formed by the sign-extended field. One read, two-cycle latency.
- R6: Mode code 4 (memory indirect) reads memory at the base register's value, then reads memory at the low `AW` bits of the returned word. The second word is the operand. Two reads, three-cycle latency.
- R7: Mode code 5 (displacement) gives memory at sign-extended field plus base register. One read, two-cycle latency.
- R8: Mode code 6 (scaled index) gives memory at sign-extended field plus base register plus index register shifted left by `scale` (scale 0..3 meaning element sizes 1, 2, 4, 8). One read, two-cycle latency.
- R9: `done` is a one-cycle pulse per accepted operation. In that cycle `wb_en`=1, `wb_idx` is the destination number captured at start, and `wb_data` is the destination register plus the operand, modulo 2^32.
- R10: A `start` that arrives while an operation is in flight has no effect: no extra `done` and no extra memory read.
- R11: Every memory address is taken modulo 2^`AW`, including sums that overflow or go negative.
- R12: Mode code 7 behaves exactly as immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 3 | Addressing mode code |
| rd_sel | input | RIW | Destination register number |
| rs_sel | input | RIW | Base register number |
| rx_sel | input | RIW | Index register number |
| field | input | 16 | Immediate value or displacement / absolute address |
| scale | input | 2 | Index shift amount (element size 1, 2, 4, 8) |
| rf_base_idx | output | RIW | Register read port A address |
| rf_base_data | input | 32 | Register read port A data |
| rf_index_idx | output | RIW | Register read port B address |
| rf_index_data | input | 32 | Register read port B data |
| rf_dst_idx | output | RIW | Register read port C address (destination) |
| rf_dst_data | input | 32 | Register read port C data |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | 32 | Memory read data, valid one cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| operand | output | 32 | Fetched operand, valid with `done` |
| wb_en | output | 1 | Write-back strobe |
| wb_idx | output | RIW | Write-back register number |
| wb_data | output | 32 | Destination plus operand |

## Verification
The bench builds the unit with its defaults: `AW` = 10 and `NREG` = 16. A 1024-word memory is small enough that 16-bit displacements and near-maximum register values wrap the address, and negative displacements wrap it below zero. Sixteen registers leave room for register 0 to hold a plain nonzero value and for register 15 to hold a value just under 2^32, which drives the scaled-index sum past the 32-bit range. The memory model returns a computed word for every address, so the pointer chain of memory indirect mode lands on a different, predictable location.

// File: rtl/amf_pkg.sv
package amf_pkg;

  localparam int AMF_DW = 32;
  localparam int AMF_FW = 16;

  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_REG  = 3'd1,
    AM_RIND = 3'd2,
    AM_DIR  = 3'd3,
    AM_MIND = 3'd4,
    AM_DISP = 3'd5,
    AM_SCL  = 3'd6,
    AM_RSV  = 3'd7
  } am_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PTR  = 2'd1,
    SQ_DATA = 2'd2
  } sq_state_e;

  function automatic logic [AMF_DW-1:0] sext_fld(input logic [AMF_FW-1:0] f);
    return {{(AMF_DW-AMF_FW){f[AMF_FW-1]}}, f};
  endfunction

  function automatic logic [AMF_DW-1:0] ea_calc(input logic [AMF_DW-1:0] disp,
                                                 input logic [AMF_DW-1:0] base,
                                                 input logic [AMF_DW-1:0] index,
                                                 input logic [1:0]        sc);
    return disp + base + (index << sc);
  endfunction

  function automatic logic [AMF_DW-1:0] wb_sum(input logic [AMF_DW-1:0] dst,
                                                input logic [AMF_DW-1:0] opnd);
    return dst + opnd;
  endfunction

  function automatic logic needs_mem(input am_mode_e m);
    return (m == AM_RIND) || (m == AM_DIR) || (m == AM_MIND) ||
           (m == AM_DISP) || (m == AM_SCL);
  endfunction

endpackage

// File: rtl/amf_addr_gen.sv
module amf_addr_gen
  import amf_pkg::*;
#(
  parameter int AW = 10
) (
  input  am_mode_e            mode_i,
  input  logic [AMF_FW-1:0]   field_i,
  input  logic [AMF_DW-1:0]   base_i,
  input  logic [AMF_DW-1:0]   index_i,
  input  logic [1:0]          scale_i,
  output logic [AW-1:0]       addr_o,
  output logic [AMF_DW-1:0]   imm_o
);

  logic [AMF_DW-1:0] disp_w;

  assign disp_w = sext_fld(field_i);
  assign imm_o  = disp_w;

  // Effective address, truncated to the memory width (wraps modulo 2^AW)
  always_comb begin
    unique case (mode_i)
      AM_DIR:  addr_o = AW'(disp_w);
      AM_DISP: addr_o = AW'(ea_calc(disp_w, base_i, '0, 2'd0));
      AM_SCL:  addr_o = AW'(ea_calc(disp_w, base_i, index_i, scale_i));
      default: addr_o = AW'(base_i);
    endcase
  end

endmodule

// File: rtl/amf_seq.sv
module amf_seq
  import amf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  am_mode_e mode_i,
  output logic     start_acc_o,
  output logic     first_rd_o,
  output logic     ptr_issue_o,
  output logic     fin_fast_o,
  output logic     fin_mem_o,
  output logic     busy_o
);

  sq_state_e state_q, state_d;

  assign busy_o      = (state_q != SQ_IDLE);
  assign start_acc_o = start_i && !busy_o;
  assign first_rd_o  = start_acc_o && needs_mem(mode_i);
  assign fin_fast_o  = start_acc_o && !needs_mem(mode_i);
  assign ptr_issue_o = (state_q == SQ_PTR);
  assign fin_mem_o   = (state_q == SQ_DATA);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (first_rd_o) state_d = (mode_i == AM_MIND) ? SQ_PTR : SQ_DATA;
      SQ_PTR:  state_d = SQ_DATA;
      SQ_DATA: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  // R6
  ptr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_issue_o |=> fin_mem_o);

endmodule

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit
  import amf_pkg::*;
#(
  parameter int AW   = 10,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         mode,
  input  logic [RIW-1:0]     rd_sel,
  input  logic [RIW-1:0]     rs_sel,
  input  logic [RIW-1:0]     rx_sel,
  input  logic [15:0]        field,
  input  logic [1:0]         scale,
  output logic [RIW-1:0]     rf_base_idx,
  input  logic [31:0]        rf_base_data,
  output logic [RIW-1:0]     rf_index_idx,
  input  logic [31:0]        rf_index_data,
  output logic [RIW-1:0]     rf_dst_idx,
  input  logic [31:0]        rf_dst_data,
  output logic               mem_rd_en,
  output logic [AW-1:0]      mem_addr,
  input  logic [31:0]        mem_rdata,
  output logic               done,
  output logic [31:0]        operand,
  output logic               wb_en,
  output logic [RIW-1:0]     wb_idx,
  output logic [31:0]        wb_data
);

  am_mode_e          mode_w;
  logic              start_acc, first_rd, ptr_issue, fin_fast, fin_mem, busy, fin_any;
  logic [AW-1:0]     ag_addr;
  logic [AMF_DW-1:0] imm_val, fast_val, opnd_nxt;
  logic              done_q;
  logic [31:0]       operand_q, wb_data_q;
  logic [RIW-1:0]    wb_idx_q, rd_q;

  assign mode_w = am_mode_e'(mode);

  amf_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .mode_i      (mode_w),
    .start_acc_o (start_acc),
    .first_rd_o  (first_rd),
    .ptr_issue_o (ptr_issue),
    .fin_fast_o  (fin_fast),
    .fin_mem_o   (fin_mem),
    .busy_o      (busy)
  );

  amf_addr_gen #(.AW(AW)) u_agen (
    .mode_i  (mode_w),
    .field_i (field),
    .base_i  (rf_base_data),
    .index_i (rf_index_data),
    .scale_i (scale),
    .addr_o  (ag_addr),
    .imm_o   (imm_val)
  );

  // Register reads: base and index are only consumed at the accepting edge
  assign rf_base_idx  = rs_sel;
  assign rf_index_idx = rx_sel;
  assign rf_dst_idx   = busy ? rd_q : rd_sel;

  // Memory port: first read from the address generator, chained read from returned word
  assign mem_rd_en = first_rd || ptr_issue;
  assign mem_addr  = ptr_issue ? AW'(mem_rdata) : ag_addr;

  assign fin_any  = fin_fast || fin_mem;
  assign fast_val = (mode_w == AM_REG) ? rf_base_data : imm_val;
  assign opnd_nxt = fin_fast ? fast_val : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      operand_q <= '0;
      wb_data_q <= '0;
      wb_idx_q  <= '0;
      rd_q      <= '0;
    end else begin
      done_q <= fin_any;
      if (start_acc) rd_q <= rd_sel;
      if (fin_any) begin
        operand_q <= opnd_nxt;
        wb_data_q <= wb_sum(rf_dst_data, opnd_nxt);
        wb_idx_q  <= fin_fast ? rd_sel : rd_q;
      end
    end
  end

  assign done    = done_q;
  assign wb_en   = done_q;
  assign operand = operand_q;
  assign wb_data = wb_data_q;
  assign wb_idx  = wb_idx_q;

  // R2
  fast_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && !needs_mem(mode_w)) |=> (done && !mem_rd_en));

  // R4
  single_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && needs_mem(mode_w) && mode_w != AM_MIND) |-> ##2 done);

  // R6
  chain_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && mode_w == AM_MIND) |-> ##3 done);

  // R6
  chain_second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && mode_w == AM_MIND) |=> (mem_rd_en && !done));

  // R10
  no_read_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_mem |-> !mem_rd_en);

endmodule

// File: tb/opnd_fetch_unit_tb.sv
`timescale 1ns/1ps
module opnd_fetch_unit_tb;

  localparam int AW   = 10;
  localparam int NREG = 16;
  localparam int RIW  = 4;
  localparam int MSZ  = 1024;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [2:0]     mode = '0;
  logic [RIW-1:0] rd_sel = '0, rs_sel = '0, rx_sel = '0;
  logic [15:0]    field = '0;
  logic [1:0]     scale = '0;
  logic [RIW-1:0] rf_base_idx, rf_index_idx, rf_dst_idx;
  logic [31:0]    rf_base_data, rf_index_data, rf_dst_data;
  logic           mem_rd_en;
  logic [AW-1:0]  mem_addr;
  logic [31:0]    mem_rdata = '0;
  logic           done, wb_en;
  logic [31:0]    operand, wb_data;
  logic [RIW-1:0] wb_idx;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;

  logic [31:0] regs [NREG];

  always #2 clk = ~clk;

  opnd_fetch_unit #(.AW(AW), .NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .rd_sel(rd_sel), .rs_sel(rs_sel), .rx_sel(rx_sel), .field(field), .scale(scale),
    .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
    .rf_index_idx(rf_index_idx), .rf_index_data(rf_index_data),
    .rf_dst_idx(rf_dst_idx), .rf_dst_data(rf_dst_data),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .operand(operand), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  function automatic logic [31:0] mem_fn(input int unsigned a);
    return 32'h5A00_0000 + (a * 32'd37) + 32'd11;
  endfunction

  function automatic logic [31:0] reg_init(input int i);
    if (i == 0)  return 32'd7;
    if (i == 15) return 32'hFFFF_FFF8;
    return 32'h100 + i * 32'h31;
  endfunction

  assign rf_base_data  = regs[rf_base_idx];
  assign rf_index_data = regs[rf_index_idx];
  assign rf_dst_data   = regs[rf_dst_idx];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_init(i);
    end else if (wb_en) begin
      regs[wb_idx] <= wb_data;
    end
    if (mem_rd_en) begin
      mem_rdata <= mem_fn(int'(mem_addr));
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Address arithmetic restated independently: signed displacement, multiply by element size, modulo memory size
  function automatic int unsigned ea_of(input logic [15:0] f, input logic [31:0] b,
                                        input logic [31:0] x, input int sc, input bit use_b, input bit use_x);
    logic [31:0] s;
    s = 32'($signed(f));
    if (use_b) s = s + b;
    if (use_x) s = s + x * (32'd1 << sc);
    return int'(s) & (MSZ - 1);
  endfunction

  task automatic run_op(input string req, input logic [2:0] m, input int rd, input int rs, input int rx,
                        input logic [15:0] f, input int sc);
    logic [31:0] exp_op, exp_wb;
    int exp_lat, exp_rds, lat, rd0;
    unique case (m)
      3'd1: begin exp_op = regs[rs]; exp_lat = 1; exp_rds = 0; end
      3'd2: begin exp_op = mem_fn(int'(regs[rs]) & (MSZ-1)); exp_lat = 2; exp_rds = 1; end
      3'd3: begin exp_op = mem_fn(ea_of(f, 0, 0, 0, 0, 0)); exp_lat = 2; exp_rds = 1; end
      3'd4: begin exp_op = mem_fn(int'(mem_fn(int'(regs[rs]) & (MSZ-1))) & (MSZ-1)); exp_lat = 3; exp_rds = 2; end
      3'd5: begin exp_op = mem_fn(ea_of(f, regs[rs], 0, 0, 1, 0)); exp_lat = 2; exp_rds = 1; end
      3'd6: begin exp_op = mem_fn(ea_of(f, regs[rs], regs[rx], sc, 1, 1)); exp_lat = 2; exp_rds = 1; end
      default: begin exp_op = 32'($signed(f)); exp_lat = 1; exp_rds = 0; end
    endcase
    exp_wb = regs[rd] + exp_op;
    @(negedge clk);
    rd0 = rd_cnt;
    mode = m; rd_sel = RIW'(rd); rs_sel = RIW'(rs); rx_sel = RIW'(rx); field = f; scale = 2'(sc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode = 3'd1; rd_sel = 4'd14; rs_sel = 4'd13; rx_sel = 4'd12; field = 16'h1234; scale = 2'd3;
    lat = 1;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(req, "latency", 32'(lat), 32'(exp_lat));
    check(req, "operand", operand, exp_op);
    check("R9", "wb_en", 32'(wb_en), 32'd1);
    check("R9", "wb_idx", 32'(wb_idx), 32'(rd));
    check("R9", "wb_data", wb_data, exp_wb);
    check(req, "memory reads", 32'(rd_cnt - rd0), 32'(exp_rds));
    @(negedge clk);
    check("R9", "done single pulse", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    check("R1", "done after reset", 32'(done), 32'd0);
    check("R1", "wb_en after reset", 32'(wb_en), 32'd0);
    check("R1", "mem_rd_en after reset", 32'(mem_rd_en), 32'd0);
  endtask

  task automatic t_busy();
    int dones, rd0, idx_seen;
    logic [31:0] r6_before, exp_op;
    r6_before = regs[6];
    exp_op = mem_fn(int'(mem_fn(int'(regs[3]) & (MSZ-1))) & (MSZ-1));
    @(negedge clk);
    rd0 = rd_cnt;
    mode = 3'd4; rd_sel = 4'd5; rs_sel = 4'd3; start = 1'b1;
    @(negedge clk);
    mode = 3'd2; rd_sel = 4'd6; rs_sel = 4'd9;
    dones = 0; idx_seen = -1;
    for (int k = 0; k < 8; k++) begin
      if (k == 1) start = 1'b0;
      if (done) begin dones++; idx_seen = int'(wb_idx); check("R10", "operand of first op", operand, exp_op); end
      @(negedge clk);
    end
    check("R10", "done count", 32'(dones), 32'd1);
    check("R10", "wb_idx", 32'(idx_seen), 32'd5);
    check("R10", "memory reads", 32'(rd_cnt - rd0), 32'd2);
    check("R10", "register 6 untouched", regs[6], r6_before);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    run_op("R2",  3'd0, 2, 0, 0, 16'h0003, 0);
    run_op("R2",  3'd0, 3, 0, 0, 16'h8001, 0);
    run_op("R12", 3'd7, 4, 9, 0, 16'hFFFE, 0);
    run_op("R3",  3'd1, 2, 0, 0, 16'h0000, 0);
    run_op("R3",  3'd1, 7, 9, 0, 16'h0000, 0);
    run_op("R4",  3'd2, 8, 4, 0, 16'h0000, 0);
    run_op("R5",  3'd3, 8, 0, 0, 16'd1001, 0);
    run_op("R11", 3'd3, 9, 0, 0, 16'h07FF, 0);
    run_op("R6",  3'd4, 10, 3, 0, 16'h0000, 0);
    run_op("R7",  3'd5, 11, 1, 0, 16'd100, 0);
    run_op("R11", 3'd5, 11, 0, 0, 16'hFFF0, 0);
    for (int sc = 0; sc < 4; sc++) run_op("R8", 3'd6, 12, 2, 5, 16'h0010, sc);
    run_op("R11", 3'd6, 13, 15, 15, 16'hFFFC, 3);
    t_busy();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule